// File: doc/BRIEF.md
# Programmable-Order CIC Decimator for One-Bit Bitstreams

This block turns the one-bit output of an external delta-sigma modulator into signed 16-bit words. A cascaded integrator-comb filter of order one, two or three runs at the modulator sample rate. The filter keeps every N-th integrator value and passes it through the same number of differentiator stages. The decimation factor N is set between 4 and 256. The sample strobe comes from a selectable edge of the modulator clock. That clock is oversampled by the system clock, so each modulator clock edge must be at least one system clock cycle wide.

Each raw filter word is scaled down to 16 bits by an arithmetic shift. The shift depends on the order and on N. A signed offset is then subtracted, with saturation, and the word is written to the result port together with a one-cycle valid pulse. The first outputs after a clear are withheld while the filter fills.

A trigger input can capture a timestamp on a chosen edge. The timestamp holds the last written result, the current decimation count and the number of results written since the last clear. Software uses these values to work out how old the result is. The configuration inputs are meant to change only while the block is idle, followed by a clear.

Top module: `cic_decim`

## Requirements
- R1: With order k (cfg_order 1, 2 or 3; the value 0 behaves as 1) and an input whose ones density is constant over every N samples, each settled raw output equals N^k times (ones minus zeros) divided by N, with a one mapped to +1 and a zero mapped to -1.
- R2: The decimation factor is N = cfg_dec_m1 + 1, from 4 to 256. Exactly one filter output is produced per N sample strobes.
- R3: Before the offset is subtracted, the raw output is arithmetic-shifted right by max(0, k*L + 1 - 16), where L is the bit length of cfg_dec_m1.
- R4: The signed cfg_offset is subtracted from the shifted value. The difference saturates to the range -32768 to +32767.
- R5: After a clear, the first k-1 filter outputs produce no result. When cfg_start is nonzero, the first k outputs produce no result.
- R6: When cfg_smp_fall is 0, a sample is taken on a rising edge of mod_clk; when it is 1, on a falling edge. mod_bit is read in the system clock cycle in which the edge is seen.
- R7: A clear loads the decimation counter with cfg_start. The first decimation then happens after N - cfg_start strobes (for cfg_start up to N-1).
- R8: A trigger edge takes a timestamp. The edge is rising when cfg_trig_fall is 0 and falling when it is 1; the opposite edge is ignored. The timestamp holds res_data, the decimation count and the written-result count as they stood before that cycle's update, and ts_valid pulses for one cycle.
- R9: Reset or a clear (clr high at a clock edge) zeroes the integrators, the combs, the result, the result count and the timestamp. Clear takes priority over a strobe or trigger in the same cycle.
- R10: res_valid is high for a single cycle, two clock cycles after the cycle in which the N-th strobe of a window is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of filter, counters, result and timestamp |
| cfg_order | input | 2 | Filter order 1 to 3 |
| cfg_dec_m1 | input | 8 | Decimation factor minus one |
| cfg_start | input | 8 | Decimation counter value loaded on clear |
| cfg_offset | input | 16 | Signed offset subtracted from each result |
| cfg_smp_fall | input | 1 | Sample on the falling modulator clock edge when 1 |
| cfg_trig_fall | input | 1 | Timestamp on the falling trigger edge when 1 |
| mod_clk | input | 1 | Modulator clock, oversampled by clk |
| mod_bit | input | 1 | Modulator data bit |
| trig_in | input | 1 | Timestamp trigger |
| res_data | output | 16 | Last aligned, offset-corrected result |
| res_valid | output | 1 | One-cycle pulse when res_data is written |
| ts_result | output | 16 | Result captured by the timestamp |
| ts_dcount | output | 8 | Decimation count captured by the timestamp |
| ts_icount | output | 8 | Written-result count captured by the timestamp |
| ts_valid | output | 1 | One-cycle pulse when a timestamp is taken |

## Verification
The trigger and the result write can fall in the same clock cycle. The timestamp must then show the old result and old result count next to a decimation count that has already wrapped to zero. The bench provokes this by raising the trigger exactly one clock after the strobe cycle of the last sample in a window. In the following cycle it checks, at the ports, the new result, the old timestamp result, the count of one and the zero decimation count, together with the result pulse timing.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int MAX_ORDER = 3;

    // order code 0 is treated as first order
    function automatic logic [1:0] order_index(input logic [1:0] ord);
        return (ord == 2'd0) ? 2'd0 : ord - 2'd1;
    endfunction

    // right shift that keeps k*L+1 significant bits within res_w
    function automatic int unsigned align_shift(input logic [1:0] oidx,
                                                input int unsigned lbits,
                                                input int unsigned res_w);
        int unsigned tot;
        tot = (int'(oidx) + 1) * lbits + 1;
        return (tot > res_w) ? tot - res_w : 0;
    endfunction

endpackage

// File: rtl/cic_edge.sv
module cic_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic fall_i,
    output logic pulse_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = sig_i;
        pulse_o = fall_i ? (prev_q & ~sig_i) : (~prev_q & sig_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cic_core.sv
module cic_core
    import cic_pkg::*;
#(
    parameter int DEC_W = 8,
    parameter int ACC_W = MAX_ORDER * DEC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             stb_i,
    input  logic             din_i,
    input  logic [1:0]       order_i,
    input  logic [DEC_W-1:0] dec_m1_i,
    input  logic [DEC_W-1:0] start_i,
    output logic [ACC_W-1:0] raw_o,
    output logic             raw_vld_o,
    output logic [DEC_W-1:0] dcnt_o
);
    localparam int NST = MAX_ORDER;

    typedef struct packed {
        logic [NST-1:0][ACC_W-1:0] integ;
        logic [NST-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]          raw;
        logic                      vld;
        logic [DEC_W-1:0]          dcnt;
        logic [1:0]                seen;
    } core_t;

    core_t q, d;
    logic [1:0] oidx;
    logic [2:0] thr;

    always_comb begin
        logic [ACC_W-1:0]          acc;
        logic [ACC_W-1:0]          v;
        logic [NST-1:0][ACC_W-1:0] cout;
        d     = q;
        d.vld = 1'b0;
        oidx  = order_index(order_i);
        thr   = {1'b0, oidx} + {2'b00, |start_i};
        acc   = din_i ? ACC_W'(1) : '1;
        v     = '0;
        cout  = '0;
        if (stb_i) begin
            // integrator chain, each stage fed by the updated previous one
            for (int s = 0; s < NST; s++) begin
                d.integ[s] = q.integ[s] + acc;
                acc        = d.integ[s];
            end
            if (q.dcnt == dec_m1_i) begin
                d.dcnt = '0;
                v      = d.integ[oidx];
                for (int s = 0; s < NST; s++) begin
                    d.dly[s] = v;
                    v        = v - q.dly[s];
                    cout[s]  = v;
                end
                d.raw = cout[oidx];
                d.vld = ({1'b0, q.seen} >= thr);
                if (q.seen != 2'd3) d.seen = q.seen + 2'd1;
            end else begin
                d.dcnt = q.dcnt + DEC_W'(1);
            end
        end
        if (clr_i) begin
            d      = '0;
            d.dcnt = start_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw_o     = q.raw;
    assign raw_vld_o = q.vld;
    assign dcnt_o    = q.dcnt;

    // R2: an output leaves only at a counter wrap caused by a strobe
    a_r2_out_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> (q.dcnt == '0 && $past(stb_i)));

    // R5: no output before the settle count covers the order
    a_r5_settled: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> ({1'b0, q.seen} >= {1'b0, oidx} + 3'd1));
endmodule

// File: rtl/cic_align.sv
module cic_align
    import cic_pkg::*;
#(
    parameter int DEC_W = 8,
    parameter int ACC_W = MAX_ORDER * DEC_W + 2,
    parameter int RES_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [ACC_W-1:0] raw_i,
    input  logic             raw_vld_i,
    input  logic [1:0]       order_i,
    input  logic [DEC_W-1:0] dec_m1_i,
    input  logic [RES_W-1:0] offset_i,
    output logic [RES_W-1:0] res_o,
    output logic             res_vld_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic signed [ACC_W:0] HI = (ACC_W+1)'(2**(RES_W-1) - 1);
    localparam logic signed [ACC_W:0] LO = ~HI;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             vld;
        logic [CNT_W-1:0] cnt;
    } al_t;

    al_t q, d;

    always_comb begin
        int unsigned             lb;
        int unsigned             sh;
        logic signed [ACC_W-1:0] shd;
        logic signed [ACC_W:0]   diff;
        lb = 0;
        for (int i = 0; i < DEC_W; i++) begin
            if (dec_m1_i[i]) lb = i + 1;
        end
        sh   = align_shift(order_index(order_i), lb, RES_W);
        shd  = $signed(raw_i) >>> sh;
        diff = $signed({shd[ACC_W-1], shd})
             - $signed({{(ACC_W+1-RES_W){offset_i[RES_W-1]}}, offset_i});
        d     = q;
        d.vld = 1'b0;
        if (raw_vld_i) begin
            if (diff > HI)      d.res = HI[RES_W-1:0];
            else if (diff < LO) d.res = LO[RES_W-1:0];
            else                d.res = diff[RES_W-1:0];
            d.vld = 1'b1;
            d.cnt = q.cnt + CNT_W'(1);
        end
        if (clr_i) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_o     = q.res;
    assign res_vld_o = q.vld;
    assign cnt_o     = q.cnt;

    // R10: the result pulse lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld);

    // R10: every write follows a raw filter output one cycle earlier
    a_r10_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> $past(raw_vld_i));
endmodule

// File: rtl/cic_decim.sv
module cic_decim
    import cic_pkg::*;
#(
    parameter int DEC_W = 8,
    parameter int RES_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       cfg_order,
    input  logic [DEC_W-1:0] cfg_dec_m1,
    input  logic [DEC_W-1:0] cfg_start,
    input  logic [RES_W-1:0] cfg_offset,
    input  logic             cfg_smp_fall,
    input  logic             cfg_trig_fall,
    input  logic             mod_clk,
    input  logic             mod_bit,
    input  logic             trig_in,
    output logic [RES_W-1:0] res_data,
    output logic             res_valid,
    output logic [RES_W-1:0] ts_result,
    output logic [DEC_W-1:0] ts_dcount,
    output logic [CNT_W-1:0] ts_icount,
    output logic             ts_valid
);
    localparam int ACC_W = MAX_ORDER * DEC_W + 2;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [DEC_W-1:0] dcnt;
        logic [CNT_W-1:0] icnt;
        logic             vld;
    } ts_t;

    logic             smp_stb, trig_stb, raw_vld;
    logic [ACC_W-1:0] raw;
    logic [DEC_W-1:0] dcnt;
    logic [CNT_W-1:0] res_cnt;
    ts_t              ts_q, ts_d;

    cic_edge u_smp_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(mod_clk), .fall_i(cfg_smp_fall), .pulse_o(smp_stb)
    );

    cic_edge u_trig_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(trig_in), .fall_i(cfg_trig_fall), .pulse_o(trig_stb)
    );

    cic_core #(.DEC_W(DEC_W), .ACC_W(ACC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .stb_i(smp_stb), .din_i(mod_bit),
        .order_i(cfg_order), .dec_m1_i(cfg_dec_m1), .start_i(cfg_start),
        .raw_o(raw), .raw_vld_o(raw_vld), .dcnt_o(dcnt)
    );

    cic_align #(.DEC_W(DEC_W), .ACC_W(ACC_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_align (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .raw_i(raw), .raw_vld_i(raw_vld),
        .order_i(cfg_order), .dec_m1_i(cfg_dec_m1), .offset_i(cfg_offset),
        .res_o(res_data), .res_vld_o(res_valid), .cnt_o(res_cnt)
    );

    // timestamp takes the registered values, i.e. before this cycle's update
    always_comb begin
        ts_d     = ts_q;
        ts_d.vld = 1'b0;
        if (trig_stb) begin
            ts_d.res  = res_data;
            ts_d.dcnt = dcnt;
            ts_d.icnt = res_cnt;
            ts_d.vld  = 1'b1;
        end
        if (clr) ts_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign ts_result = ts_q.res;
    assign ts_dcount = ts_q.dcnt;
    assign ts_icount = ts_q.icnt;
    assign ts_valid  = ts_q.vld;

    // R8: a timestamp pulse needs a trigger edge in the previous cycle
    a_r8_ts_from_trig: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> $past(trig_stb));

    // R8: without trigger or clear the captured result holds
    a_r8_ts_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_stb && !clr) |=> $stable(ts_result));

    // R9: a clear empties the result path and the timestamp
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (res_cnt == '0 && !res_valid && !ts_valid && res_data == '0));
endmodule

// File: tb/cic_decim_tb.sv
module cic_decim_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  cfg_order = 2'd1;
    logic [7:0]  cfg_dec_m1 = 8'd3;
    logic [7:0]  cfg_start = 8'd0;
    logic [15:0] cfg_offset = 16'd0;
    logic        cfg_smp_fall = 1'b0;
    logic        cfg_trig_fall = 1'b0;
    logic        mod_clk = 1'b0;
    logic        mod_bit = 1'b0;
    logic        trig_in = 1'b0;
    logic [15:0] res_data, ts_result;
    logic [7:0]  ts_dcount, ts_icount;
    logic        res_valid, ts_valid;

    int errors = 0;
    int checks = 0;
    int res_n = 0, ts_n = 0;
    int last_res = 0, ts_r = 0, ts_d = 0, ts_i = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cic_decim u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_order(cfg_order),
        .cfg_dec_m1(cfg_dec_m1), .cfg_start(cfg_start), .cfg_offset(cfg_offset),
        .cfg_smp_fall(cfg_smp_fall), .cfg_trig_fall(cfg_trig_fall),
        .mod_clk(mod_clk), .mod_bit(mod_bit), .trig_in(trig_in),
        .res_data(res_data), .res_valid(res_valid), .ts_result(ts_result),
        .ts_dcount(ts_dcount), .ts_icount(ts_icount), .ts_valid(ts_valid)
    );

    always @(negedge clk) begin
        if (res_valid) begin
            res_n++;
            last_res = $signed(res_data);
        end
        if (ts_valid) begin
            ts_n++;
            ts_r = $signed(ts_result);
            ts_d = ts_dcount;
            ts_i = ts_icount;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic setup(input int ord, input int n, input int st, input int off, input bit sfall);
        @(negedge clk);
        cfg_order = 2'(ord); cfg_dec_m1 = 8'(n - 1); cfg_start = 8'(st);
        cfg_offset = 16'(off); cfg_smp_fall = sfall; cfg_trig_fall = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        settle();
    endtask

    // one modulator period: bit on the rising half, another on the falling half
    task automatic smp2(input bit b_r, input bit b_f);
        @(negedge clk); mod_bit = b_r; mod_clk = 1'b1;
        @(negedge clk); mod_bit = b_f; mod_clk = 1'b0;
    endtask

    // pattern bits taken from pat LSB first, cyclic with period per
    task automatic stream(input int cnt, input int pat, input int per);
        for (int i = 0; i < cnt; i++) smp2(pat[i % per], pat[i % per]);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = ~trig_in;
        @(negedge clk); trig_in = ~trig_in;
        settle();
    endtask

    task automatic t_reset();
        check("R9 reset res_data", int'(res_data), 0);
        check("R9 reset res_valid", int'(res_valid), 0);
        check("R9 reset ts_valid", int'(ts_valid), 0);
    endtask

    task automatic t_first_order();
        int b;
        setup(1, 4, 0, 0, 1'b0);
        b = res_n;
        stream(4, 1, 1); settle();
        check("R1 k1 N4 ones count", res_n - b, 1);
        check("R1 k1 N4 ones value", last_res, 4);
        stream(4, 0, 1); settle();
        check("R2 k1 N4 one result per window", res_n - b, 2);
        check("R3 k1 N4 zeros value, no shift", last_res, -4);
    endtask

    task automatic t_third_order();
        int b;
        setup(3, 32, 0, 100, 1'b0);
        b = res_n;
        stream(64, 4'b1011, 4); settle();
        check("R5 k3 first two outputs withheld", res_n - b, 0);
        stream(32, 4'b1011, 4); settle();
        check("R5 k3 third output written", res_n - b, 1);
        check("R4 k3 N32 density 3/4 minus offset", last_res, 16284);
        setup(3, 32, 0, 0, 1'b0);
        stream(96, 1, 1); settle();
        check("R4 k3 N32 full scale saturates", last_res, 32767);
    endtask

    task automatic t_second_order();
        int b;
        setup(2, 256, 0, -5, 1'b0);
        b = res_n;
        stream(512, 4'b0001, 4); settle();
        check("R5 k2 one withheld then one result", res_n - b, 1);
        check("R3 k2 N256 shift by one, negative offset", last_res, -16379);
        setup(2, 256, 0, 1, 1'b0);
        stream(512, 0, 1); settle();
        check("R4 k2 N256 negative saturation", last_res, -32768);
    endtask

    task automatic t_edge_select();
        setup(1, 8, 0, 0, 1'b0);
        for (int i = 0; i < 8; i++) smp2(1'b1, 1'b0);
        settle();
        check("R6 rising edge reads rising-half bit", last_res, 8);
        setup(1, 8, 0, 0, 1'b1);
        for (int i = 0; i < 8; i++) smp2(1'b1, 1'b0);
        settle();
        check("R6 falling edge reads falling-half bit", last_res, -8);
    endtask

    task automatic t_start_value();
        int b, bt;
        setup(1, 8, 5, 0, 1'b0);
        b = res_n; bt = ts_n;
        stream(3, 1, 1); settle();
        pulse_trig();
        check("R7 counter wrapped after N-start strobes", ts_d, 0);
        check("R7 partial first output withheld", res_n - b, 0);
        stream(7, 1, 1); settle();
        check("R7 no result before next full window", res_n - b, 0);
        stream(1, 1, 1); settle();
        check("R7 result after 11 strobes", res_n - b, 1);
        check("R7 value of first full window", last_res, 8);
        check("R8 one timestamp taken", ts_n - bt, 1);
    endtask

    task automatic t_timestamp();
        int bt;
        setup(1, 4, 0, 0, 1'b0);
        bt = ts_n;
        stream(11, 1, 1); settle();
        @(negedge clk); trig_in = 1'b1;
        settle();
        check("R8 rising trigger captures", ts_n - bt, 1);
        check("R8 captured result", ts_r, 4);
        check("R8 captured decimation count", ts_d, 3);
        check("R8 captured result count", ts_i, 2);
        @(negedge clk); trig_in = 1'b0;
        settle();
        check("R8 falling trigger ignored in rising mode", ts_n - bt, 1);
        @(negedge clk); cfg_trig_fall = 1'b1;
        @(negedge clk); trig_in = 1'b1;
        settle();
        check("R8 rising trigger ignored in falling mode", ts_n - bt, 1);
        @(negedge clk); trig_in = 1'b0;
        settle();
        check("R8 falling trigger captures", ts_n - bt, 2);
        @(negedge clk); cfg_trig_fall = 1'b0;
    endtask

    task automatic t_coincide();
        setup(1, 4, 0, 0, 1'b0);
        stream(4, 1, 1);
        stream(3, 0, 1);
        @(negedge clk); mod_bit = 1'b0; mod_clk = 1'b1;
        @(negedge clk);
        check("R10 no result one cycle after strobe", int'(res_valid), 0);
        mod_clk = 1'b0; trig_in = 1'b1;
        @(negedge clk);
        check("R10 result two cycles after strobe", int'(res_valid), 1);
        check("R10 new result value", int'($signed(res_data)), -4);
        check("R8 same-cycle trigger pulse", int'(ts_valid), 1);
        check("R8 same-cycle trigger keeps old result", int'($signed(ts_result)), 4);
        check("R8 same-cycle trigger keeps old count", int'(ts_icount), 1);
        check("R8 same-cycle trigger sees wrapped count", int'(ts_dcount), 0);
        trig_in = 1'b0;
        @(negedge clk);
        check("R10 result pulse one cycle wide", int'(res_valid), 0);
        settle();
    endtask

    task automatic t_clear();
        int b;
        setup(1, 4, 0, 0, 1'b0);
        stream(6, 1, 1); settle();
        check("R9 before clear result present", last_res, 4);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        #1;
        check("R9 clear zeroes result", int'(res_data), 0);
        pulse_trig();
        check("R9 clear zeroes result seen by timestamp", ts_r, 0);
        check("R9 clear zeroes decimation count", ts_d, 0);
        check("R9 clear zeroes result count", ts_i, 0);
        b = res_n;
        stream(3, 1, 1); settle();
        check("R9 no early result after clear", res_n - b, 0);
        stream(1, 1, 1); settle();
        check("R9 result after one full window", res_n - b, 1);
        check("R9 clean value after clear", last_res, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_first_order();
        t_third_order();
        t_second_order();
        t_edge_select();
        t_start_value();
        t_timestamp();
        t_coincide();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule